// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block is one bank of general-purpose pins behind a small register port. Each pin has three paths. The input is synchronised, and software reads it through a read-only register. The output value and its enable are written by software and sent straight to the pads. An interrupt detector sits on the synchronised input and watches for one of five trigger conditions: rising edge, falling edge, both edges, high level or low level. Three per-pin control bits pick the condition: sense type, dual edge and polarity. A detected event sets a sticky pending bit. Software reads the pending bits either raw or gated by a per-pin enable mask, and clears them by writing ones. The bank has one interrupt line, which is high while any enabled pending bit is set.

The bank also holds pad settings and drives them out unchanged. These are a pull direction, a pull enable and a 3-bit drive-strength code per pin. The drive-strength code is spread over three consecutive registers, and each of these holds one bit of the code for every pin. The register offsets are fixed, so an existing driver can program the bank without changes.

Top module: `gpio_bank`

## Requirements
- R1: After reset every writable register, every pending bit, the interrupt line and all pad outputs are zero, and each register reads as zero.
- R2: The input register (offset 0x00) returns the pin levels after SYNC_STAGES rising clock edges. Register bits at or above NPINS always read as zero.
- R3: The output value (0x04), output enable (0x08), pull direction (0x34, 1 = up) and pull enable (0x38) registers read back as written. Each one drives its own pad output port directly.
- R4: Drive-strength bit i of every pin is held in the register at 0x58 + 4*i, for i = 0..2. The 3-bit code of pin n appears on pad_drive[3n+2:3n], and bit i of the code is the bit from register i.
- R5: In edge mode (sense bit at 0x0c = 0), with dual edge off (0x10 = 0) and polarity (0x14) = 1, only a rising input sets the pending bit.
- R6: In edge mode with dual edge off and polarity 0, only a falling input sets the pending bit.
- R7: In edge mode with the dual-edge bit at 1, both rising and falling inputs set the pending bit, whatever the polarity.
- R8: With the sense bit at 1 (level), the pending bit is set on every cycle that the synchronised input equals the polarity bit. If a pending bit is cleared while its level is still active, it reads as set again.
- R9: Masked status (0x20) reads as raw status AND the enable mask (0x18, 1 = enabled). The irq output is the OR of all masked status bits.
- R10: Writing a 1 to a bit of the clear register (0x24) clears that pending bit, and writing a 0 leaves it unchanged. An event detected in the same cycle as the clear still leaves the bit set.
- R11: Writes to the input (0x00), raw status (0x1c) and masked status (0x20) offsets have no effect.
- R12: A change at a pin reaches the raw status register SYNC_STAGES + 1 rising edges after it is applied.

Register reads are combinational: bus_rdata follows bus_addr in the same cycle. Writes take effect at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pin_in | input | NPINS | Pad input levels |
| pin_out | output | NPINS | Pad output values |
| pin_oe | output | NPINS | Pad output enables |
| pad_pull_up | output | NPINS | Pull direction, 1 = up |
| pad_pull_en | output | NPINS | Pull enable |
| pad_drive | output | 3*NPINS | Drive-strength code per pin |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the bank with NPINS = 12, ADDR_W = 9 and SYNC_STAGES = 3. Because NPINS is narrower than the 32-bit bus, a full-width write shows that the upper register bits read as zero. The three-stage synchroniser separates the input-read latency from the status latency, so an off-by-one in either is caught. With twelve pins, each trigger mode can be exercised on its own pin while the other pins carry the pending bits of earlier steps.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int BUS_W    = 32;
   localparam int DRV_BITS = 3;

   localparam logic [31:0] OFS_IN    = 32'h00;
   localparam logic [31:0] OFS_DOUT  = 32'h04;
   localparam logic [31:0] OFS_OE    = 32'h08;
   localparam logic [31:0] OFS_SENSE = 32'h0c;
   localparam logic [31:0] OFS_DUAL  = 32'h10;
   localparam logic [31:0] OFS_POL   = 32'h14;
   localparam logic [31:0] OFS_MASK  = 32'h18;
   localparam logic [31:0] OFS_RAW   = 32'h1c;
   localparam logic [31:0] OFS_MSTAT = 32'h20;
   localparam logic [31:0] OFS_CLR   = 32'h24;
   localparam logic [31:0] OFS_PSEL  = 32'h34;
   localparam logic [31:0] OFS_PEN   = 32'h38;
   localparam logic [31:0] OFS_DRV   = 32'h58;

   typedef enum logic [3:0] {
      SEL_NONE, SEL_IN, SEL_DOUT, SEL_OE, SEL_SENSE, SEL_DUAL, SEL_POL,
      SEL_MASK, SEL_RAW, SEL_MSTAT, SEL_CLR, SEL_PSEL, SEL_PEN, SEL_DRV
   } reg_sel_e;

   function automatic reg_sel_e decode_sel(logic [31:0] a);
      reg_sel_e s;
      s = SEL_NONE;
      if (a == OFS_IN)         s = SEL_IN;
      else if (a == OFS_DOUT)  s = SEL_DOUT;
      else if (a == OFS_OE)    s = SEL_OE;
      else if (a == OFS_SENSE) s = SEL_SENSE;
      else if (a == OFS_DUAL)  s = SEL_DUAL;
      else if (a == OFS_POL)   s = SEL_POL;
      else if (a == OFS_MASK)  s = SEL_MASK;
      else if (a == OFS_RAW)   s = SEL_RAW;
      else if (a == OFS_MSTAT) s = SEL_MSTAT;
      else if (a == OFS_CLR)   s = SEL_CLR;
      else if (a == OFS_PSEL)  s = SEL_PSEL;
      else if (a == OFS_PEN)   s = SEL_PEN;
      else if (a >= OFS_DRV && a < OFS_DRV + 32'(4 * DRV_BITS) && a[1:0] == 2'b00)
         s = SEL_DRV;
      return s;
   endfunction
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_bank_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[0] <= '0;
      else        stage[0] <= d;
   end

   for (genvar gs = 1; gs < STAGES; gs++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage[gs] <= '0;
         else        stage[gs] <= stage[gs-1];
      end
   end

   assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_bank_detect.sv
module gpio_bank_detect #(
   parameter int NPINS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] lvl_in,
   input  logic [NPINS-1:0] sense,
   input  logic [NPINS-1:0] dual,
   input  logic [NPINS-1:0] pol,
   output logic [NPINS-1:0] hit
);
   logic [NPINS-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= lvl_in;
   end

   for (genvar gp = 0; gp < NPINS; gp++) begin : g_pin
      logic rise, fall, edge_hit;
      assign rise     = lvl_in[gp] & ~prev[gp];
      assign fall     = ~lvl_in[gp] & prev[gp];
      assign edge_hit = dual[gp] ? (rise | fall) : (pol[gp] ? rise : fall);
      assign hit[gp]  = sense[gp] ? (lvl_in[gp] == pol[gp]) : edge_hit;
   end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int NPINS  = 32,
   parameter int ADDR_W = 9
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         addr,
   input  logic                      we,
   input  logic [NPINS-1:0]          wdat,
   output logic [BUS_W-1:0]          rdat,
   input  logic [NPINS-1:0]          in_sync,
   input  logic [NPINS-1:0]          hit,
   output logic [NPINS-1:0]          dout_q,
   output logic [NPINS-1:0]          oe_q,
   output logic [NPINS-1:0]          sense_q,
   output logic [NPINS-1:0]          dual_q,
   output logic [NPINS-1:0]          pol_q,
   output logic [NPINS-1:0]          mask_q,
   output logic [NPINS-1:0]          pend_q,
   output logic [NPINS-1:0]          psel_q,
   output logic [NPINS-1:0]          pen_q,
   output logic [DRV_BITS*NPINS-1:0] drv_flat
);
   reg_sel_e         sel;
   logic [1:0]       drv_idx;
   logic [NPINS-1:0] clr_vec;
   logic [NPINS-1:0] drv_q [DRV_BITS];

   assign sel     = decode_sel(32'(addr));
   assign drv_idx = 2'((32'(addr) - OFS_DRV) >> 2);
   assign clr_vec = (we && sel == SEL_CLR) ? wdat : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= '0; oe_q <= '0; sense_q <= '0; dual_q <= '0;
         pol_q  <= '0; mask_q <= '0; psel_q <= '0; pen_q  <= '0;
      end else if (we) begin
         case (sel)
            SEL_DOUT:  dout_q  <= wdat;
            SEL_OE:    oe_q    <= wdat;
            SEL_SENSE: sense_q <= wdat;
            SEL_DUAL:  dual_q  <= wdat;
            SEL_POL:   pol_q   <= wdat;
            SEL_MASK:  mask_q  <= wdat;
            SEL_PSEL:  psel_q  <= wdat;
            SEL_PEN:   pen_q   <= wdat;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_vec) | hit;
   end

   for (genvar gb = 0; gb < DRV_BITS; gb++) begin : g_drv
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) drv_q[gb] <= '0;
         else if (we && sel == SEL_DRV && drv_idx == 2'(gb)) drv_q[gb] <= wdat;
      end
      for (genvar gp = 0; gp < NPINS; gp++) begin : g_bit
         assign drv_flat[gp*DRV_BITS + gb] = drv_q[gb][gp];
      end
   end

   always_comb begin
      rdat = '0;
      case (sel)
         SEL_IN:    rdat[NPINS-1:0] = in_sync;
         SEL_DOUT:  rdat[NPINS-1:0] = dout_q;
         SEL_OE:    rdat[NPINS-1:0] = oe_q;
         SEL_SENSE: rdat[NPINS-1:0] = sense_q;
         SEL_DUAL:  rdat[NPINS-1:0] = dual_q;
         SEL_POL:   rdat[NPINS-1:0] = pol_q;
         SEL_MASK:  rdat[NPINS-1:0] = mask_q;
         SEL_RAW:   rdat[NPINS-1:0] = pend_q;
         SEL_MSTAT: rdat[NPINS-1:0] = pend_q & mask_q;
         SEL_PSEL:  rdat[NPINS-1:0] = psel_q;
         SEL_PEN:   rdat[NPINS-1:0] = pen_q;
         SEL_DRV: begin
            for (int i = 0; i < DRV_BITS; i++)
               if (drv_idx == 2'(i)) rdat[NPINS-1:0] = drv_q[i];
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_bank_pkg::*;
#(
   parameter int NPINS       = 32,
   parameter int ADDR_W      = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic                      bus_we,
   input  logic [BUS_W-1:0]          bus_wdata,
   output logic [BUS_W-1:0]          bus_rdata,
   input  logic [NPINS-1:0]          pin_in,
   output logic [NPINS-1:0]          pin_out,
   output logic [NPINS-1:0]          pin_oe,
   output logic [NPINS-1:0]          pad_pull_up,
   output logic [NPINS-1:0]          pad_pull_en,
   output logic [DRV_BITS*NPINS-1:0] pad_drive,
   output logic                      irq
);
   if (NPINS < 1 || NPINS > BUS_W) begin : g_bad_npins
      $error("gpio_bank: NPINS must be 1..32");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("gpio_bank: ADDR_W too small for the register map");
   end

   logic [NPINS-1:0] sync_w, hit_w, pend_w, mask_w, sense_w, dual_w, pol_w;

   gpio_bank_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_w)
   );

   gpio_bank_detect #(.NPINS(NPINS)) u_detect (
      .clk(clk), .rst_n(rst_n), .lvl_in(sync_w), .sense(sense_w),
      .dual(dual_w), .pol(pol_w), .hit(hit_w)
   );

   gpio_bank_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
      .wdat(bus_wdata[NPINS-1:0]), .rdat(bus_rdata),
      .in_sync(sync_w), .hit(hit_w),
      .dout_q(pin_out), .oe_q(pin_oe), .sense_q(sense_w), .dual_q(dual_w),
      .pol_q(pol_w), .mask_q(mask_w), .pend_q(pend_w),
      .psel_q(pad_pull_up), .pen_q(pad_pull_en), .drv_flat(pad_drive)
   );

   assign irq = |(pend_w & mask_w);
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
   import gpio_bank_pkg::*;
#(
   parameter int NPINS  = 32,
   parameter int ADDR_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [BUS_W-1:0]  bus_wdata,
   input logic [NPINS-1:0]  pend,
   input logic [NPINS-1:0]  hit,
   input logic [NPINS-1:0]  mask,
   input logic [NPINS-1:0]  pin_oe,
   input logic              irq
);
   logic clr_wr, oe_wr;
   assign clr_wr = bus_we && (32'(bus_addr) == OFS_CLR);
   assign oe_wr  = bus_we && (32'(bus_addr) == OFS_OE);

   p_reset_zero_r1: assert property (@(posedge clk)
      !rst_n |=> (pend == '0 && pin_oe == '0 && !irq));

   p_oe_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_wr |=> $stable(pin_oe));

   p_pend_needs_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend & ~$past(pend) & ~$past(hit)) == '0);

   p_irq_needs_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (mask != '0));

   p_event_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(hit) & ~pend) == '0));

   p_clear_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> ((pend & $past(bus_wdata[NPINS-1:0] & ~hit)) == '0));
endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_gpio_bank_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
   .bus_wdata(bus_wdata), .pend(pend_w), .hit(hit_w), .mask(mask_w),
   .pin_oe(pin_oe), .irq(irq)
);

// File: tb/gpio_bank_bench.sv
`timescale 1ns/10ps
module gpio_bank_bench;
   import gpio_bank_pkg::*;

   localparam int NP = 12;
   localparam int AW = 9;
   localparam int SS = 3;

   typedef enum {K_RD, K_IRQ, K_OUT, K_OE, K_PSEL, K_PEN, K_DRV} kind_e;
   typedef struct {
      kind_e       kind;
      logic [63:0] exp;
      string       tag;
   } item_t;

   logic clk = 1'b0;
   logic rst_n;
   logic [AW-1:0] bus_addr;
   logic bus_we;
   logic [BUS_W-1:0] bus_wdata, bus_rdata;
   logic [NP-1:0] pin_in, pin_out, pin_oe, pad_pull_up, pad_pull_en;
   logic [DRV_BITS*NP-1:0] pad_drive;
   logic irq;

   item_t sbq[$];
   event ev_push;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   gpio_bank #(.NPINS(NP), .ADDR_W(AW), .SYNC_STAGES(SS)) u_gpio_bank (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .pad_pull_up(pad_pull_up),
      .pad_pull_en(pad_pull_en), .pad_drive(pad_drive), .irq(irq)
   );

   // monitor: pops expected items and compares against the outputs
   initial begin
      item_t it;
      logic [63:0] act;
      forever begin
         @(ev_push);
         #0.1;
         while (sbq.size() > 0) begin
            it = sbq.pop_front();
            case (it.kind)
               K_RD:    act = 64'(bus_rdata);
               K_IRQ:   act = 64'(irq);
               K_OUT:   act = 64'(pin_out);
               K_OE:    act = 64'(pin_oe);
               K_PSEL:  act = 64'(pad_pull_up);
               K_PEN:   act = 64'(pad_pull_en);
               default: act = 64'(pad_drive);
            endcase
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic push(kind_e k, logic [63:0] e, string t);
      item_t it;
      it.kind = k; it.exp = e; it.tag = t;
      sbq.push_back(it);
      ->ev_push;
      #0.2;
   endtask

   task automatic rd(logic [31:0] a, logic [63:0] e, string t);
      bus_addr = AW'(a);
      push(K_RD, e, t);
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [31:0] a, logic [31:0] d);
      bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   initial begin
      #100000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
      cyc(3);
      rst_n = 1'b1;
      // R1 reset state
      rd(OFS_DOUT, 0, "R1 dout");
      rd(OFS_MASK, 0, "R1 mask");
      rd(OFS_RAW, 0, "R1 raw");
      push(K_OE, 0, "R1 pin_oe");
      push(K_IRQ, 0, "R1 irq");
      push(K_DRV, 0, "R1 drive");
      cyc(1);
      // R2 / R12 input latency
      pin_in = 12'hA5C;
      cyc(SS - 1);
      rd(OFS_IN, 0, "R2 not yet synchronised");
      cyc(1);
      rd(OFS_IN, 12'hA5C, "R2 input read");
      wr(OFS_IN, 32'hFFFF_FFFF);
      rd(OFS_IN, 12'hA5C, "R11 input write ignored");
      rd(OFS_RAW, 0, "R6 rising ignored with polarity 0");
      // R6 falling edges, R12 latency
      pin_in = '0;
      cyc(SS);
      rd(OFS_RAW, 0, "R12 status one edge after sync");
      cyc(1);
      rd(OFS_RAW, 12'hA5C, "R6 falling sets pending");
      rd(OFS_MSTAT, 0, "R9 masked with mask 0");
      push(K_IRQ, 0, "R9 irq masked off");
      wr(OFS_MASK, 32'h00F);
      rd(OFS_MSTAT, 12'h00C, "R9 masked status");
      push(K_IRQ, 1, "R9 irq asserted");
      wr(OFS_CLR, 32'h008);
      rd(OFS_RAW, 12'hA54, "R10 clear one bit");
      rd(OFS_MSTAT, 12'h004, "R10 masked after clear");
      wr(OFS_CLR, 32'h000);
      rd(OFS_RAW, 12'hA54, "R10 zero write no effect");
      wr(OFS_RAW, 32'hFFF);
      rd(OFS_RAW, 12'hA54, "R11 raw write ignored");
      wr(OFS_MSTAT, 32'h000);
      rd(OFS_MSTAT, 12'h004, "R11 masked write ignored");
      wr(OFS_CLR, 32'hFFF);
      rd(OFS_RAW, 0, "R10 clear all");
      push(K_IRQ, 0, "R9 irq low after clear");
      // R5 rising only
      wr(OFS_POL, 32'hFFF);
      pin_in = 12'h001;
      cyc(SS + 1);
      rd(OFS_RAW, 12'h001, "R5 rising sets");
      wr(OFS_CLR, 32'h001);
      pin_in = 12'h000;
      cyc(SS + 1);
      rd(OFS_RAW, 0, "R5 falling ignored");
      // R7 dual edge
      wr(OFS_DUAL, 32'h002);
      pin_in = 12'h002;
      cyc(SS + 1);
      rd(OFS_RAW, 12'h002, "R7 rising");
      wr(OFS_CLR, 32'h002);
      rd(OFS_RAW, 0, "R7 cleared");
      pin_in = 12'h000;
      cyc(SS + 1);
      rd(OFS_RAW, 12'h002, "R7 falling");
      wr(OFS_CLR, 32'hFFF);
      // R8 level sensing on pin 4
      wr(OFS_SENSE, 32'h010);
      rd(OFS_RAW, 0, "R8 level inactive");
      pin_in = 12'h010;
      cyc(SS + 1);
      rd(OFS_RAW, 12'h010, "R8 active high");
      wr(OFS_CLR, 32'h010);
      rd(OFS_RAW, 12'h010, "R8 reasserts after clear");
      pin_in = 12'h000;
      cyc(SS + 1);
      wr(OFS_CLR, 32'h010);
      rd(OFS_RAW, 0, "R8 level gone");
      wr(OFS_POL, 32'hFEF);
      rd(OFS_RAW, 0, "R8 one cycle before active low");
      cyc(1);
      rd(OFS_RAW, 12'h010, "R8 active low");
      wr(OFS_SENSE, 32'h000);
      wr(OFS_CLR, 32'hFFF);
      rd(OFS_RAW, 0, "R8 back to edge mode");
      // R3 pad registers
      wr(OFS_DOUT, 32'hFFFF_F0F0);
      push(K_OUT, 12'h0F0, "R3 pin_out");
      rd(OFS_DOUT, 12'h0F0, "R2 upper bits read zero");
      wr(OFS_OE, 32'h0FF);
      push(K_OE, 12'h0FF, "R3 pin_oe");
      rd(OFS_OE, 12'h0FF, "R3 oe readback");
      wr(OFS_PSEL, 32'h123);
      push(K_PSEL, 12'h123, "R3 pull select");
      wr(OFS_PEN, 32'h456);
      push(K_PEN, 12'h456, "R3 pull enable");
      rd(OFS_PEN, 12'h456, "R3 pull enable readback");
      // R4 bit-sliced drive strength
      wr(OFS_DRV, 32'h001);
      wr(OFS_DRV + 4, 32'h800);
      wr(OFS_DRV + 8, 32'h001);
      push(K_DRV, 64'h5 | (64'h2 << 33), "R4 drive codes");
      rd(OFS_DRV + 4, 12'h800, "R4 slice 1 readback");
      rd(OFS_DRV + 8, 12'h001, "R4 slice 2 readback");
      cyc(2);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule